// File: doc/BRIEF.md
# Completion Interrupt Line Aggregator

This block folds the completion activity of many storage completion queues into one level-sensitive interrupt pin. It holds one pending bit per queue. Each bit is set when a completion is posted to a queue whose interrupt is enabled. It is cleared when the host writes that queue's head doorbell and the new head has caught up with the tail. The pin stays high for as long as any pending bit is not hidden by the interrupt mask. It does not pulse.

The host changes the 32-bit mask through two registers. One sets mask bits and the other clears them, and a read of either returns the mask. The pin level is worked out again on every cycle, so a mask change, a post or a drain all show on the pin at the same edge. When the controller runs in message-signalled mode, the pin stays low. In that mode, posts, doorbells and mask writes change nothing.

Top module: `cq_irq_aggregator`

## Requirements
- R1: A post (`post_vld`) to a queue `post_qid` whose bit in `q_irq_en` is 1, with `msi_mode` low, sets that queue's pending bit.
- R2: `irq_pin` is registered. At each rising edge it takes the value (any pending bit AND NOT its mask bit) using the state written at that same edge, so it is visible after the edge at which the causing input is sampled.
- R3: A doorbell (`db_vld`) to an enabled queue clears its pending bit only when `db_head` equals `db_tail`. When they differ, the doorbell has no effect.
- R4: A post or doorbell to a queue whose `q_irq_en` bit is 0 leaves that queue's pending bit unchanged.
- R5: While `msi_mode` is high, `irq_pin` is 0 after the next edge, and posts, doorbells and mask writes are all ignored. Pending bits keep their value, so the pin reappears once `msi_mode` drops.
- R6: A write to address 0x0C ORs `reg_wdata` into the mask, and a write to 0x10 clears every mask bit written as 1. `reg_rdata` returns the mask when `reg_addr` is 0x0C or 0x10, and 0 at any other address.
- R7: Every mask change updates `irq_pin` at the same edge as the write.
- R8: Mask bit i hides queue i only for i < 32. Pending bits of queues 32 to 63 are never masked.
- R9: If a post and a draining doorbell target the same queue in one cycle, the pending bit ends up set.
- R10: After reset the mask is 0, no bit is pending and `irq_pin` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msi_mode | input | 1 | Message-signalled mode: pin quiet, events and mask writes ignored |
| q_irq_en | input | 64 | Per-queue interrupt enable |
| post_vld | input | 1 | Completion posted this cycle |
| post_qid | input | 6 | Queue id of the post |
| db_vld | input | 1 | Completion-queue head doorbell written this cycle |
| db_qid | input | 6 | Queue id of the doorbell |
| db_head | input | 16 | New head value written by the host |
| db_tail | input | 16 | Current tail of that queue |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Mask readback (0 at other offsets) |
| irq_pin | output | 1 | Level-sensitive interrupt line |

## Verification
Every result here arrives one edge after its cause: the pin and the mask readback both reflect inputs sampled at the previous rising edge. The read data is combinational on the address but follows the mask register. The bench therefore drives a cycle's inputs on the falling edge and pushes the pin and readback that its own model expects after the coming rising edge. A monitor pops each item a quarter period after that edge, so every comparison sees exactly one update. Corner cases such as a post and a drain in the same cycle, and a drain while the queue is disabled, are observed through the pin with the mask chosen so that the bit in question is the only pending bit.

// File: rtl/cq_irq_aggregator.sv
module cq_irq_aggregator #(
  parameter int NUM_Q   = 64,
  parameter int MASK_W  = 32,
  parameter int PTR_W   = 16,
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] SET_OFS = 8'h0C,
  parameter logic [ADDR_W-1:0] CLR_OFS = 8'h10,
  localparam int QID_W  = $clog2(NUM_Q)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              msi_mode,
  input  logic [NUM_Q-1:0]  q_irq_en,
  input  logic              post_vld,
  input  logic [QID_W-1:0]  post_qid,
  input  logic              db_vld,
  input  logic [QID_W-1:0]  db_qid,
  input  logic [PTR_W-1:0]  db_head,
  input  logic [PTR_W-1:0]  db_tail,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq_pin
);

  logic [NUM_Q-1:0]  pend, pend_nx, set_vec, clr_vec, mask_ext_nx;
  logic [MASK_W-1:0] mask, mask_nx;
  logic              post_ok, db_ok, set_hit, clr_hit, irq_nx;

  assign post_ok = post_vld & q_irq_en[post_qid] & ~msi_mode;
  assign db_ok   = db_vld & q_irq_en[db_qid] & ~msi_mode & (db_head == db_tail);
  assign set_hit = reg_wr & ~msi_mode & (reg_addr == SET_OFS);
  assign clr_hit = reg_wr & ~msi_mode & (reg_addr == CLR_OFS);

  assign set_vec = post_ok ? (NUM_Q'(1) << post_qid) : '0;
  assign clr_vec = db_ok   ? (NUM_Q'(1) << db_qid)   : '0;
  assign pend_nx = (pend & ~clr_vec) | set_vec;

  always_comb begin
    mask_nx = mask;
    if (set_hit) mask_nx = mask_nx | reg_wdata[MASK_W-1:0];
    if (clr_hit) mask_nx = mask_nx & ~reg_wdata[MASK_W-1:0];
  end

  for (genvar g = 0; g < NUM_Q; g++) begin : g_mask
    if (g < MASK_W) begin : g_cov
      assign mask_ext_nx[g] = mask_nx[g];
    end else begin : g_open
      assign mask_ext_nx[g] = 1'b0;
    end
  end

  assign irq_nx = ~msi_mode & |(pend_nx & ~mask_ext_nx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend    <= '0;
      mask    <= '0;
      irq_pin <= 1'b0;
    end else begin
      pend    <= pend_nx;
      mask    <= mask_nx;
      irq_pin <= irq_nx;
    end
  end

  assign reg_rdata = (reg_addr == SET_OFS || reg_addr == CLR_OFS) ? DATA_W'(mask) : '0;

  p_post_sets_r1: assert property (@(posedge clk) disable iff (!rst_n)
    post_ok |=> pend[$past(post_qid)]);

  p_drain_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (db_ok && !(post_ok && post_qid == db_qid)) |=> !pend[$past(db_qid)]);

  p_idle_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!post_ok && !db_ok) |=> $stable(pend));

  p_msi_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |=> !irq_pin);

  p_msi_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    msi_mode |=> $stable(mask));

  p_rise_needs_pin_mode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_pin) |-> $past(!msi_mode));

  p_high_ids_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!msi_mode && !db_vld && |(pend >> MASK_W)) |=> irq_pin);

endmodule

// File: tb/sim_cq_irq_aggregator.sv
module sim_cq_irq_aggregator;
  logic        clk = 0, rst_n = 0;
  logic        msi_mode = 0;
  logic [63:0] q_irq_en = '1;
  logic        post_vld = 0, db_vld = 0, reg_wr = 0;
  logic [5:0]  post_qid = 0, db_qid = 0;
  logic [15:0] db_head = 0, db_tail = 0;
  logic [7:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic        irq_pin;

  always #10 clk = ~clk;

  cq_irq_aggregator u0 (
    .clk(clk), .rst_n(rst_n), .msi_mode(msi_mode), .q_irq_en(q_irq_en),
    .post_vld(post_vld), .post_qid(post_qid), .db_vld(db_vld), .db_qid(db_qid),
    .db_head(db_head), .db_tail(db_tail), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_pin(irq_pin));

  typedef struct { logic pin; logic [31:0] rd; string tag; } exp_t;
  exp_t sbq[$];
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;
  logic [63:0] m_pend = '0, en_req = '1;
  logic [31:0] m_mask = '0;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic pv, input int pq, input logic dv, input int dq,
                     input int hd, input int tl, input logic wr, input logic [7:0] ad,
                     input logic [31:0] wd, input logic msi, input string tag);
    exp_t e;
    @(negedge clk);
    q_irq_en = en_req; msi_mode = msi;
    post_vld = pv; post_qid = 6'(pq); db_vld = dv; db_qid = 6'(dq);
    db_head = 16'(hd); db_tail = 16'(tl);
    reg_wr = wr; reg_addr = ad; reg_wdata = wd;
    if (!msi) begin
      if (wr && ad == 8'h0C) m_mask = m_mask | wd;
      if (wr && ad == 8'h10) m_mask = m_mask & ~wd;
      if (dv && en_req[dq] && hd == tl) m_pend[dq] = 1'b0;
      if (pv && en_req[pq]) m_pend[pq] = 1'b1;
    end
    e.pin = !msi && |(m_pend & ~{32'h0, m_mask});
    e.rd  = (ad == 8'h0C || ad == 8'h10) ? m_mask : 32'h0;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h0C, 0, 0, tag);
  endtask

  always @(posedge clk) begin
    #5;
    if (sbq.size() > 0) begin
      exp_t e;
      e = sbq.pop_front();
      chk({31'h0, irq_pin}, {31'h0, e.pin}, {e.tag, " pin"});
      chk(reg_rdata, e.rd, {e.tag, " rdata"});
    end
  end

  initial begin
    #(20 * 5000);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    reg_addr = 8'h0C;
    #45;
    chk({31'h0, irq_pin}, 0, "R10 reset pin");
    chk(reg_rdata, 0, "R10 reset mask");
    rst_n = 1;
    idle("R10 idle after reset");

    cyc(1, 3, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R1 post q3");
    cyc(0, 0, 1, 3, 4, 7, 0, 8'h0C, 0, 0, "R3 head!=tail keeps");
    cyc(0, 0, 1, 3, 7, 7, 0, 8'h0C, 0, 0, "R3 drain clears");

    en_req[5] = 0;
    cyc(1, 5, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R4 post disabled q5");
    idle("R4 q5 still clear");

    cyc(1, 2, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R1 post q2");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h0C, 32'h4, 0, "R7 mask set hides q2");
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h10, 0, 0, "R6 read via clear offset");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h0C, 32'h10, 0, "R6 set ORs bits");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h10, 32'h4, 0, "R7 mask clear shows q2");
    cyc(0, 0, 1, 2, 9, 9, 0, 8'h10, 0, 0, "R3 drain q2");
    cyc(0, 0, 0, 0, 0, 0, 0, 8'h14, 0, 0, "R6 other offset reads 0");

    cyc(1, 40, 0, 0, 0, 0, 1, 8'h0C, 32'hFFFF_FFFF, 0, "R8 q40 with full mask");
    idle("R8 q40 stays visible");
    cyc(0, 0, 1, 40, 1, 1, 0, 8'h0C, 0, 0, "R3 drain q40");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h10, 32'hFFFF_FFFF, 0, "R6 clear all");

    cyc(1, 1, 0, 0, 0, 0, 0, 8'h0C, 0, 1, "R5 post ignored in msi");
    idle("R5 nothing pending after msi post");
    cyc(0, 0, 0, 0, 0, 0, 1, 8'h0C, 32'hFF, 1, "R5 mask write ignored");
    idle("R5 mask still 0");
    cyc(1, 1, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R1 post q1");
    cyc(0, 0, 1, 1, 3, 3, 0, 8'h0C, 0, 1, "R5 pin low, drain ignored");
    idle("R5 pending kept, pin back");
    cyc(0, 0, 1, 1, 3, 3, 0, 8'h0C, 0, 0, "R3 drain q1");

    cyc(1, 7, 1, 7, 2, 2, 0, 8'h0C, 0, 0, "R9 same-cycle set wins");
    idle("R9 q7 held");
    cyc(0, 0, 1, 7, 2, 2, 0, 8'h0C, 0, 0, "R3 drain q7");

    cyc(1, 9, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R1 post q9");
    en_req[9] = 0;
    cyc(0, 0, 1, 9, 5, 5, 0, 8'h0C, 0, 0, "R4 drain disabled q9");
    en_req[9] = 1;
    cyc(0, 0, 1, 9, 5, 5, 0, 8'h0C, 0, 0, "R3 drain q9 re-enabled");
    cyc(1, 12, 1, 13, 0, 0, 1, 8'h0C, 32'h1000, 0, "R2 post and mask same edge");
    cyc(1, 33, 0, 0, 0, 0, 0, 8'h0C, 0, 0, "R2 high id pin");
    idle("R2 final");
    idle("R2 final idle");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule